// File: doc/BRIEF.md
# Serial Command Port for TDM Switch Memories

This block is the host-facing serial slave of a small time-division switch. A host selects it with an active-low chip select and clocks bytes in on a receive line. Replies go out on a transmit line that has its own output enable. Every access is one microcycle of two bytes. The first is a command/address byte, which carries an opcode and a stream/channel address. The second is a data byte, sent by the host for writes and returned by the block for reads.

The chip select, serial clock and receive line are asynchronous to the system clock. Each passes through a synchronizer of configurable depth, and serial clock edges are detected in the system domain. Decoded accesses go to the switch's memory arbiter as a held request that waits for a grant. Read data returns one or more cycles later on a valid strobe. Writes may be chained under one chip select. A read must close the selection, and any command after it is refused.

Top module: `uport_slave`

## Requirements
- R1: Bytes are shifted MSB first on synchronized rising serial clock edges, and the first byte after chip select falls is a command byte. Its bit 7 is the stream, bits 6..2 are the channel, and bits 1..0 are the opcode. The request address is {stream, channel}.
- R2: Opcode 01 writes the connect memory in connection mode (mem_tgt=0, mem_msg=0). Opcode 11 writes it in message mode (mem_tgt=0, mem_msg=1).
- R3: Opcode 00 reads the connect memory (mem_tgt=0) and opcode 10 reads the data memory (mem_tgt=1). Both issue a request with mem_we=0, write data zero and mem_msg=0 as soon as the command byte completes, before the data byte.
- R4: Read data is driven MSB first on txd, one bit per synchronized falling serial clock edge of the data byte. txd_oe stays low through the command byte and rises at the first falling edge of the data byte.
- R5: Within SYNC_STAGES+2 cycles of chip select going high, txd_oe and cmd_err are low. Both are low after reset.
- R6: Any number of write microcycles (command byte, then data byte) may follow one another under a single chip select. Each one produces its own write request.
- R7: A command byte received after a read microcycle under the same chip select produces no request. It also sets cmd_err, which stays high until chip select rises.
- R8: mem_req stays high, with address, data and flags unchanged, until the cycle in which mem_gnt is high.
- R9: Chip select rising in the middle of a byte discards the partial byte and issues no request. The next selection starts again with a command byte.
- R10: A write request carries the data byte and is issued only after that byte's eighth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host |
| rxd | input | 1 | Serial data from host |
| txd | output | 1 | Serial data to host |
| txd_oe | output | 1 | Output enable for txd (high = driven) |
| cmd_err | output | 1 | Command refused after a read under the same selection |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_tgt | output | 1 | 0 = connect memory, 1 = data memory |
| mem_msg | output | 1 | Write mode: 0 = connection, 1 = message |
| mem_addr | output | ADDR_W | {stream, channel} |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Arbiter accepts the pending request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench drives the port bit by bit at a slow serial clock. A scoreboard compares every memory request with the one the host sequence implies, so a misaligned bit counter shows up as a wrong address or opcode. A wrong bit order shows up as scrambled read data. A chip select dropped after four bits tests whether the partial byte is discarded: a design that keeps it decodes the next write at the wrong address, and the read-back exposes it. A command sent after a read must raise cmd_err with no request. A design that accepts it produces an unexpected request, and the read-back shows the overwritten location. Grants delayed by several cycles test whether a write request is held until accepted.

// File: rtl/uport_pkg.sv
package uport_pkg;

   typedef enum logic [1:0] {
      OP_RD_CONN = 2'b00,
      OP_WR_CONN = 2'b01,
      OP_RD_DATA = 2'b10,
      OP_WR_MSG  = 2'b11
   } uport_op_e;

   typedef enum logic [1:0] {
      PH_CMD  = 2'b00,
      PH_DATA = 2'b01,
      PH_DONE = 2'b10,
      PH_LOCK = 2'b11
   } uport_ph_e;

   function automatic logic op_is_read(input logic [1:0] op);
      return !op[0];
   endfunction

endpackage

// File: rtl/uport_sync.sv
module uport_sync #(
   parameter int              STAGES  = 2,
   parameter int              W       = 1,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uport_front.sv
module uport_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic rxd,
   output logic sel,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic rx_bit
);
   logic [2:0] s;
   logic       sclk_d;

   uport_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, rxd}),
      .q     (s)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= s[1];

   assign sel       = !s[2];
   assign sclk_rise = sel &&  s[1] && !sclk_d;
   assign sclk_fall = sel && !s[1] &&  sclk_d;
   assign rx_bit    = s[0];
endmodule

// File: rtl/uport_framer.sv
module uport_framer
   import uport_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          rise,
   input  logic          rx_bit,
   output logic          iss_v,
   output logic          iss_we,
   output logic          iss_tgt,
   output logic          iss_msg,
   output logic [AW-1:0] iss_addr,
   output logic [DW-1:0] iss_wdata,
   output logic          rd_phase,
   output logic          cmd_err
);
   localparam int CW = $clog2(DW);

   uport_ph_e     phase;
   logic [CW-1:0] bcnt;
   logic [DW-2:0] shreg;
   logic [DW-1:0] cmd_q;
   logic [DW-1:0] byte_w;
   logic          last;

   assign byte_w   = {shreg, rx_bit};
   assign last     = (bcnt == CW'(DW-1));
   assign rd_phase = (phase == PH_DATA) && op_is_read(cmd_q[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         bcnt      <= '0;
         shreg     <= '0;
         cmd_q     <= '0;
         cmd_err   <= 1'b0;
         iss_v     <= 1'b0;
         iss_we    <= 1'b0;
         iss_tgt   <= 1'b0;
         iss_msg   <= 1'b0;
         iss_addr  <= '0;
         iss_wdata <= '0;
      end else begin
         iss_v <= 1'b0;
         if (!sel) begin
            phase   <= PH_CMD;
            bcnt    <= '0;
            cmd_err <= 1'b0;
         end else if (rise) begin
            shreg <= byte_w[DW-2:0];
            bcnt  <= last ? '0 : bcnt + 1'b1;
            if (last) begin
               case (phase)
                  PH_CMD: begin
                     cmd_q <= byte_w;
                     phase <= PH_DATA;
                     if (op_is_read(byte_w[1:0])) begin
                        iss_v     <= 1'b1;
                        iss_we    <= 1'b0;
                        iss_tgt   <= byte_w[1];
                        iss_msg   <= 1'b0;
                        iss_addr  <= byte_w[DW-1:2];
                        iss_wdata <= '0;
                     end
                  end
                  PH_DATA: begin
                     if (op_is_read(cmd_q[1:0])) begin
                        phase <= PH_DONE;
                     end else begin
                        phase     <= PH_CMD;
                        iss_v     <= 1'b1;
                        iss_we    <= 1'b1;
                        iss_tgt   <= 1'b0;
                        iss_msg   <= cmd_q[1];
                        iss_addr  <= cmd_q[DW-1:2];
                        iss_wdata <= byte_w;
                     end
                  end
                  PH_DONE: begin
                     cmd_err <= 1'b1;
                     phase   <= PH_LOCK;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/uport_txser.sv
module uport_txser #(
   parameter int DW        = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          fall,
   input  logic          rd_phase,
   input  logic          rvalid,
   input  logic [DW-1:0] rdata,
   output logic          txd,
   output logic          txd_oe
);
   logic [DW-1:0] sh;
   logic          q;
   logic          oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
         q  <= 1'b0;
         oe <= 1'b0;
      end else begin
         if (rvalid) begin
            sh <= rdata;
         end else if (sel && fall && rd_phase) begin
            sh <= {sh[DW-2:0], 1'b0};
         end
         if (!sel) begin
            oe <= 1'b0;
         end else if (fall && rd_phase) begin
            q  <= sh[DW-1];
            oe <= 1'b1;
         end
      end
   end

   if (PARK_ZERO) begin : g_park
      assign txd = oe ? q : 1'b0;
   end else begin : g_hold
      assign txd = q;
   end
   assign txd_oe = oe;
endmodule

// File: rtl/uport_reqhold.sv
module uport_reqhold #(
   parameter int DW = 8,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iss_v,
   input  logic          iss_we,
   input  logic          iss_tgt,
   input  logic          iss_msg,
   input  logic [AW-1:0] iss_addr,
   input  logic [DW-1:0] iss_wdata,
   input  logic          mem_gnt,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_tgt,
   output logic          mem_msg,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_tgt   <= 1'b0;
         mem_msg   <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (iss_v) begin
         mem_req   <= 1'b1;
         mem_we    <= iss_we;
         mem_tgt   <= iss_tgt;
         mem_msg   <= iss_msg;
         mem_addr  <= iss_addr;
         mem_wdata <= iss_wdata;
      end else if (mem_req && mem_gnt) begin
         mem_req <= 1'b0;
      end
   end
endmodule

// File: rtl/uport_slave.sv
module uport_slave #(
   parameter int SYNC_STAGES   = 2,
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 6,
   parameter bit TXD_PARK_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              rxd,
   output logic              txd,
   output logic              txd_oe,
   output logic              cmd_err,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_tgt,
   output logic              mem_msg,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uport_slave: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W + 2 != DATA_W) begin : g_bad_width
      $error("uport_slave: command byte must hold address plus 2-bit opcode");
   end

   logic              cs_act, rise, fall, rx_bit;
   logic              iss_v, iss_we, iss_tgt, iss_msg, rd_phase;
   logic [ADDR_W-1:0] iss_addr;
   logic [DATA_W-1:0] iss_wdata;

   uport_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .rxd       (rxd),
      .sel       (cs_act),
      .sclk_rise (rise),
      .sclk_fall (fall),
      .rx_bit    (rx_bit)
   );

   uport_framer #(.DW(DATA_W), .AW(ADDR_W)) i_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (cs_act),
      .rise      (rise),
      .rx_bit    (rx_bit),
      .iss_v     (iss_v),
      .iss_we    (iss_we),
      .iss_tgt   (iss_tgt),
      .iss_msg   (iss_msg),
      .iss_addr  (iss_addr),
      .iss_wdata (iss_wdata),
      .rd_phase  (rd_phase),
      .cmd_err   (cmd_err)
   );

   uport_txser #(.DW(DATA_W), .PARK_ZERO(TXD_PARK_ZERO)) i_txser (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (cs_act),
      .fall     (fall),
      .rd_phase (rd_phase),
      .rvalid   (mem_rvalid),
      .rdata    (mem_rdata),
      .txd      (txd),
      .txd_oe   (txd_oe)
   );

   uport_reqhold #(.DW(DATA_W), .AW(ADDR_W)) i_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_v     (iss_v),
      .iss_we    (iss_we),
      .iss_tgt   (iss_tgt),
      .iss_msg   (iss_msg),
      .iss_addr  (iss_addr),
      .iss_wdata (iss_wdata),
      .mem_gnt   (mem_gnt),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_tgt   (mem_tgt),
      .mem_msg   (mem_msg),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );
endmodule

// File: rtl/uport_chk.sv
module uport_chk #(
   parameter int DW = 8,
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_act,
   input logic          txd_oe,
   input logic          cmd_err,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic          mem_we,
   input logic          mem_tgt,
   input logic          mem_msg,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata
);
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata) && $stable(mem_tgt) && $stable(mem_msg));

   p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !txd_oe);

   p_err_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !cmd_err);

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err && cs_act |=> cmd_err);

   p_err_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> !$rose(mem_req));

   p_oe_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txd_oe) |-> $past(cs_act));

   p_wr_conn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_tgt);

   p_rd_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> (mem_wdata == '0) && !mem_msg);
endmodule

bind uport_slave uport_chk #(.DW(DATA_W), .AW(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_act    (cs_act),
   .txd_oe    (txd_oe),
   .cmd_err   (cmd_err),
   .mem_req   (mem_req),
   .mem_gnt   (mem_gnt),
   .mem_we    (mem_we),
   .mem_tgt   (mem_tgt),
   .mem_msg   (mem_msg),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata)
);

// File: tb/test_uport_slave.sv
module test_uport_slave;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 16;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cs_n = 1'b1, sclk = 1'b1, rxd = 1'b0;
   logic       mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [7:0] mem_rdata = 8'h00;
   logic       txd, txd_oe, cmd_err, mem_req, mem_we, mem_tgt, mem_msg;
   logic [5:0] mem_addr;
   logic [7:0] mem_wdata;

   uport_slave i_uport_slave (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .rxd(rxd),
      .txd(txd), .txd_oe(txd_oe), .cmd_err(cmd_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_msg(mem_msg),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int         n_chk = 0, n_fail = 0;
   int         gnt_lat = 0;
   logic [16:0] exp_q [$];
   logic [7:0] cm_exp [64];

   function automatic logic [7:0] dm_val(input logic [5:0] a);
      return {a, 2'b01} ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor and memory model
   initial begin
      int wc = 0;
      bit pend = 0;
      logic [7:0]  pv = 8'h00;
      logic [16:0] act, e;
      forever begin
         @(negedge clk);
         mem_gnt = 1'b0;
         mem_rvalid = 1'b0;
         if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata = pv;
            pend = 0;
         end
         if (rst_n && mem_req) begin
            if (wc < gnt_lat) wc++;
            else begin
               wc = 0;
               mem_gnt = 1'b1;
               act = {mem_we, mem_tgt, mem_msg, mem_addr, mem_wdata};
               if (exp_q.size() == 0) check(1'b0, "R7 R9 unexpected request", 32'(act), 0);
               else begin
                  e = exp_q.pop_front();
                  check(act == e, "R1 R2 R3 R10 request fields", 32'(act), 32'(e));
               end
               if (!mem_we) begin
                  pend = 1;
                  pv = mem_tgt ? dm_val(mem_addr) : cm_exp[mem_addr];
               end
            end
         end
      end
   end

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
      oe_all = 1;
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         sclk = 1'b0;
         rxd = tx[i];
         repeat (H) @(negedge clk);
         rx[i] = txd;
         oe_all = oe_all & txd_oe;
         sclk = 1'b1;
         repeat (H) @(negedge clk);
      end
   endtask

   task automatic sel_start();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic sel_end();
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   function automatic logic [7:0] cmdb(input logic [1:0] op, input logic st, input logic [4:0] ch);
      return {st, ch, op};
   endfunction

   task automatic wr(input logic [1:0] op, input logic st, input logic [4:0] ch, input logic [7:0] d);
      logic [7:0] r;
      bit o;
      exp_q.push_back({1'b1, 1'b0, op[1], st, ch, d});
      cm_exp[{st, ch}] = d;
      xfer(cmdb(op, st, ch), r, o);
      xfer(d, r, o);
   endtask

   task automatic rd(input logic [1:0] op, input logic st, input logic [4:0] ch);
      logic [7:0] r, ev;
      bit o;
      exp_q.push_back({1'b0, op[1], 1'b0, st, ch, 8'h00});
      xfer(cmdb(op, st, ch), r, o);
      check(txd_oe == 1'b0, "R4 txd_oe low before data byte", 32'(txd_oe), 0);
      ev = op[1] ? dm_val({st, ch}) : cm_exp[{st, ch}];
      xfer(8'h00, r, o);
      check(r == ev, "R3 R4 read data MSB first", 32'(r), 32'(ev));
      check(o, "R4 txd_oe high during data byte", 32'(o), 1);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) cm_exp[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!txd_oe && !mem_req && !cmd_err, "R5 reset state",
            32'({txd_oe, mem_req, cmd_err}), 0);

      // R1 R2 R10: single writes in both modes
      sel_start(); wr(2'b01, 1'b0, 5'd5, 8'hA5); sel_end();
      sel_start(); wr(2'b11, 1'b1, 5'd31, 8'h3C); sel_end();
      check(exp_q.size() == 0, "R2 write requests drained", 32'(exp_q.size()), 0);

      // R3 R4 R5: reads of both memories
      sel_start(); rd(2'b00, 1'b0, 5'd5); sel_end();
      check(txd_oe == 1'b0, "R5 txd_oe released after deselect", 32'(txd_oe), 0);
      sel_start(); rd(2'b00, 1'b1, 5'd31); sel_end();
      sel_start(); rd(2'b10, 1'b1, 5'd0); sel_end();
      sel_start(); rd(2'b10, 1'b0, 5'd19); sel_end();

      // R6 R8: chained writes with slow grants
      gnt_lat = 3;
      sel_start();
      wr(2'b01, 1'b0, 5'd1, 8'h81);
      wr(2'b11, 1'b1, 5'd2, 8'h42);
      wr(2'b01, 1'b1, 5'd30, 8'h17);
      sel_end();
      check(exp_q.size() == 0, "R6 R8 chained writes all granted", 32'(exp_q.size()), 0);
      gnt_lat = 0;
      sel_start(); rd(2'b00, 1'b0, 5'd1); sel_end();
      sel_start(); rd(2'b00, 1'b1, 5'd30); sel_end();

      // R7: command after read under same select is refused
      begin
         logic [7:0] r;
         bit o;
         sel_start();
         rd(2'b00, 1'b1, 5'd2);
         xfer(cmdb(2'b01, 1'b0, 5'd9), r, o);
         xfer(8'hEE, r, o);
         repeat (4) @(negedge clk);
         check(cmd_err == 1'b1, "R7 cmd_err raised", 32'(cmd_err), 1);
         sel_end();
         check(cmd_err == 1'b0, "R5 cmd_err cleared on deselect", 32'(cmd_err), 0);
         check(exp_q.size() == 0, "R7 no request for refused command", 32'(exp_q.size()), 0);
      end
      sel_start(); rd(2'b00, 1'b0, 5'd9); sel_end();

      // R9: abort mid-byte
      sel_start();
      for (int i = 7; i >= 4; i--) begin
         @(negedge clk); sclk = 1'b0; rxd = cmdb(2'b01, 1'b1, 5'd7) >> i;
         repeat (H) @(negedge clk); sclk = 1'b1; repeat (H) @(negedge clk);
      end
      sel_end();
      check(exp_q.size() == 0 && !mem_req, "R9 partial byte dropped", 32'(mem_req), 0);
      sel_start(); wr(2'b01, 1'b0, 5'd12, 8'hC3); sel_end();
      sel_start(); rd(2'b00, 1'b0, 5'd12); sel_end();
      check(exp_q.size() == 0, "R9 realigned after abort", 32'(exp_q.size()), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule